// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write a bank of 128 eight-bit configuration registers. Every access is a single two-byte frame sent while slave select is held low. The first byte names the register in its upper seven bits and gives the direction in its lowest bit. The second byte is either the value to store or, on a read, a dummy byte. During that dummy byte the slave shifts the register's content back on MISO.

The three SPI inputs are brought into the system clock domain through synchronisers. SCLK edges are detected there, so the whole block is a single synchronous design. When a write frame completes, a one-cycle strobe carries its address and data to the register file, and the same strobe is visible at the block's edge. Chip-side logic reads any register through a combinational read port.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is 16 bits, MSB first, under one low period of ss_n. The first byte holds the register address in bits [7:1] and the direction in bit [0], where 1 means write. On a write, the second byte is stored at that address. For example, writing 28h to register 2Bh sends 57h then 28h.
- R2: On a read (bit [0] = 0, so reading 2Bh sends 56h), MISO carries the addressed register's eight bits, MSB first, during the second byte. The incoming second byte is ignored and the register keeps its value.
- R3: SPI mode 0 is used: SCLK idles low, MOSI is sampled on the rising edge and MISO changes after the falling edge. Operation is correct when clk runs at least 8 times faster than SCLK, for example 25 MHz SCLK with a 200 MHz clk.
- R4: While ss_n is high, miso_oe and miso are both 0. During the first byte of any frame, miso is 0.
- R5: If ss_n rises before the sixteenth bit, the frame is dropped: no strobe, no register change. The next frame starts again from bit 0.
- R6: wr_stb is high for exactly one clk cycle per completed write frame, after the sixteenth bit, with wr_addr and wr_data valid. Read frames raise no strobe.
- R7: After reset (rst_n low, sampled on clk), every register reads 0, wr_stb is 0 and miso_oe is 0.
- R8: SCLK pulses after the sixteenth bit are ignored until ss_n goes high, so a write with extra clocks stores the second byte once.
- R9: host_rd_data shows the register at host_rd_addr combinationally. In the cycle where wr_stb is high it still shows the old value, and from the next cycle it shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the master |
| ss_n | input | 1 | SPI slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, low when deselected |
| miso_oe | output | 1 | High while the slave drives MISO |
| wr_stb | output | 1 | One-cycle write commit strobe |
| wr_addr | output | 7 | Register address of the committed write |
| wr_data | output | 8 | Data of the committed write |
| host_rd_addr | input | 7 | Chip-side read address |
| host_rd_data | output | 8 | Chip-side read data |

## Verification
A write commit and a chip-side read of the same register can fall in the same clk cycle. The bench provokes this by pointing host_rd_addr at a register before sending a write frame to it. At the clk cycle in which wr_stb is high, it records host_rd_data and expects the old value. On the following cycle it expects the new one. Because the frames run at the fastest permitted SCLK, a read frame that returns data proves the MISO load completes inside one half SCLK period.

// File: rtl/spi_ra_pkg.sv
// Shared constants and types for the SPI register access slave.
// Assumes: one frame = header byte + data byte.
package spi_ra_pkg;
    localparam int ADDR_W_DEF  = 7;
    localparam int DATA_W_DEF  = 8;
    localparam int SYNC_ST_DEF = 2;

    // Direction flag carried in bit 0 of the header byte.
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/spi_ra_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous inputs.
// Assumes: each bit is independently glitch-free and slow versus clk.
module spi_ra_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ra_engine.sv
// Frame engine: detects SCLK edges on synchronised inputs, shifts in
// the header and data, loads read data for MISO and raises the write strobe.
// Assumes: clk >= 8x SCLK, inputs already synchronised.
module spi_ra_engine
    import spi_ra_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    localparam int HDR_W   = ADDR_W + 1,
    localparam int FRAME_W = HDR_W + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic               sclk_q;
    logic               rise, fall, active;
    logic [FRAME_W-1:0] shreg;
    logic [DATA_W-1:0]  tx;
    dir_e               hdr_dir, last_dir;

    assign active = ~ss_n_s;
    assign rise   = active &  sclk_s & ~sclk_q;
    assign fall   = active & ~sclk_s &  sclk_q;

    // Header fields once the first byte is complete.
    assign rd_addr = shreg[HDR_W-1:1];
    assign hdr_dir = dir_e'(shreg[0]);
    // Header fields one bit before the frame ends.
    assign last_dir = dir_e'(shreg[DATA_W-1]);

    // Delayed SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Receive shift register and bit counter; cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (rise && bit_cnt < CNT_W'(FRAME_W)) begin
            shreg   <= {shreg[FRAME_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Transmit register: load on the falling edge after the header, then shift.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            tx <= '0;
        end else if (fall && bit_cnt == CNT_W'(HDR_W)) begin
            tx <= (hdr_dir == DIR_READ) ? rd_data : '0;
        end else if (fall && bit_cnt > CNT_W'(HDR_W) && bit_cnt < CNT_W'(FRAME_W)) begin
            tx <= {tx[DATA_W-2:0], 1'b0};
        end
    end

    // One-cycle write strobe on the last rising edge of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (rise && bit_cnt == CNT_W'(FRAME_W - 1) && last_dir == DIR_WRITE) begin
                wr_stb  <= 1'b1;
                wr_addr <= shreg[FRAME_W-2:DATA_W];
                wr_data <= {shreg[DATA_W-2:0], mosi_s};
            end
        end
    end

    assign miso    = active & tx[DATA_W-1];
    assign miso_oe = active;
endmodule

// File: rtl/spi_ra_regfile.sv
// Register bank written by the frame strobe, with two combinational read ports.
// Assumes: a single writer; reads see the old value during the write cycle.
module spi_ra_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        // Storage for one register, cleared on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem[g] <= '0;
            else if (we && waddr == ADDR_W'(g))  mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/spi_regbank_slave.sv
// Top: SPI mode-0 slave giving register read/write access to a bank.
// Assumes: clk >= 8x SCLK; synchronous active-low reset.
module spi_regbank_slave
    import spi_ra_pkg::*;
#(
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int DATA_W      = DATA_W_DEF,
    parameter int SYNC_STAGES = SYNC_ST_DEF,
    localparam int FRAME_W = ADDR_W + 1 + DATA_W,
    localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] spi_rd_addr;
    logic [DATA_W-1:0] spi_rd_data;
    logic [CNT_W-1:0]  bit_cnt;

    spi_ra_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sclk, mosi}),
        .q     (pins_s)
    );

    spi_ra_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[1]),
        .ss_n_s  (pins_s[2]),
        .mosi_s  (pins_s[0]),
        .rd_addr (spi_rd_addr),
        .rd_data (spi_rd_data),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .miso    (miso),
        .miso_oe (miso_oe),
        .bit_cnt (bit_cnt)
    );

    spi_ra_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_stb),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (spi_rd_addr),
        .rdata_a (spi_rd_data),
        .raddr_b (host_rd_addr),
        .rdata_b (host_rd_data)
    );
endmodule

// File: rtl/spi_regbank_slave_chk.sv
// Checker for the SPI register access slave, bound to the top module.
module spi_regbank_slave_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso,
    input logic              miso_oe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] host_rd_addr,
    input logic [DATA_W-1:0] host_rd_data,
    input logic [CNT_W-1:0]  bit_cnt
);
    localparam int HDR_W = ADDR_W + 1;

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    a_r6_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> miso_oe);

    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso);

    a_r4_header_low: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && bit_cnt < CNT_W'(HDR_W)) |-> !miso);

    a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && host_rd_addr == wr_addr) |=>
        (host_rd_addr != $past(host_rd_addr) || host_rd_data == $past(wr_data)));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miso         (miso),
    .miso_oe      (miso_oe),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .host_rd_addr (host_rd_addr),
    .host_rd_data (host_rd_data),
    .bit_cnt      (bit_cnt)
);

// File: tb/spi_regbank_slave_test.sv
`timescale 1ns/1ps
module spi_regbank_slave_test;
    localparam int HALF = 4;  // clk cycles per SCLK half period: 25 MHz

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic [6:0] host_rd_addr = '0;
    logic       miso, miso_oe, wr_stb;
    logic [6:0] wr_addr;
    logic [7:0] wr_data, host_rd_data;

    spi_regbank_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data)
    );

    always #2.5 clk = ~clk;

    int tests = 0, fails = 0;
    int stb_cnt = 0;
    logic [6:0] last_addr = '0;
    logic [7:0] last_data = '0, during_val = '0, after_val = '0;
    logic prev_stb = 1'b0;

    // Monitor the strobe and the host read port away from the clk edge.
    always @(negedge clk) begin
        if (prev_stb) after_val = host_rd_data;
        if (wr_stb) begin
            stb_cnt++;
            last_addr = wr_addr;
            last_data = wr_data;
            during_val = host_rd_data;
        end
        prev_stb = wr_stb;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    // One master transfer of nbits clocks; beyond 16 bits MOSI is held high.
    task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                        output logic [7:0] rx_hdr, output logic [7:0] rx_dat);
        logic [15:0] txw;
        txw = {b0, b1};
        rx_hdr = '0;
        rx_dat = '0;
        ss_n = 1'b0;
        half_wait();
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? txw[15-i] : 1'b1;
            half_wait();
            if (i < 8)       rx_hdr = {rx_hdr[6:0], miso};
            else if (i < 16) rx_dat = {rx_dat[6:0], miso};
            sclk = 1'b1;
            half_wait();
            sclk = 1'b0;
        end
        half_wait();
        ss_n = 1'b1;
        mosi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Vector: {is_write, addr[6:0], data[7:0], expected[7:0]}
    localparam logic [23:0] VEC [9] = '{
        {1'b1, 7'h2B, 8'h28, 8'h00},
        {1'b0, 7'h2B, 8'h00, 8'h28},
        {1'b1, 7'h00, 8'hFF, 8'h00},
        {1'b1, 7'h7F, 8'hA5, 8'h00},
        {1'b0, 7'h7F, 8'h00, 8'hA5},
        {1'b0, 7'h00, 8'h00, 8'hFF},
        {1'b0, 7'h10, 8'h00, 8'h00},
        {1'b1, 7'h10, 8'h5A, 8'h00},
        {1'b0, 7'h10, 8'h00, 8'h5A}
    };

    initial begin
        logic [7:0] rh, rd;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: reset state.
        check("R7 miso_oe", miso_oe, 0);
        check("R7 miso", miso, 0);
        check("R7 wr_stb", wr_stb, 0);
        for (int a = 0; a < 128; a++) begin
            host_rd_addr = 7'(a);
            #1 check("R7 reg zero", host_rd_data, 0);
        end

        // Vector walk: R1 writes, R2 reads, R6 strobe per write.
        for (int v = 0; v < 9; v++) begin
            logic        is_wr;
            logic [6:0]  ad;
            logic [7:0]  dt, ex;
            {is_wr, ad, dt, ex} = VEC[v];
            base = stb_cnt;
            host_rd_addr = ad;
            if (is_wr) begin
                xfer({ad, 1'b1}, dt, 16, rh, rd);
                check("R6 one strobe per write", stb_cnt - base, 1);
                check("R1 wr_addr", last_addr, ad);
                check("R1 wr_data", last_data, dt);
                check("R1 stored", host_rd_data, dt);
            end else begin
                xfer({ad, 1'b0}, ~ex, 16, rh, rd);
                check("R2 miso data", rd, ex);
                check("R6 no strobe on read", stb_cnt - base, 0);
                check("R2 dummy ignored", host_rd_data, ex);
            end
            check("R4 header miso low", rh, 0);
            check("R4 idle oe", miso_oe, 0);
        end

        // R1 worked header: write 2Bh sends 57h.
        check("R1 header 57h", {7'h2B, 1'b1}, 8'h57);

        // R5: aborted write after 12 bits.
        base = stb_cnt;
        host_rd_addr = 7'h05;
        xfer({7'h05, 1'b1}, 8'h99, 12, rh, rd);
        check("R5 abort no strobe", stb_cnt - base, 0);
        check("R5 abort no change", host_rd_data, 0);
        xfer({7'h2B, 1'b0}, 8'h00, 16, rh, rd);
        check("R5 fresh frame after abort", rd, 8'h28);

        // R8: write with 20 clocks stores once.
        base = stb_cnt;
        host_rd_addr = 7'h06;
        xfer({7'h06, 1'b1}, 8'hC3, 20, rh, rd);
        check("R8 single strobe", stb_cnt - base, 1);
        check("R8 value kept", host_rd_data, 8'hC3);

        // R9: host read during the strobe cycle versus after it.
        host_rd_addr = 7'h2B;
        xfer({7'h2B, 1'b1}, 8'h77, 16, rh, rd);
        check("R9 old during strobe", during_val, 8'h28);
        check("R9 new after strobe", after_val, 8'h77);

        // R3: read at max SCLK returns every bit, including alternating ones.
        xfer({7'h7F, 1'b0}, 8'h00, 16, rh, rd);
        check("R3 mode0 read", rd, 8'hA5);

        // R7: reset mid-run clears the bank.
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        host_rd_addr = 7'h7F;
        #1 check("R7 cleared after reset", host_rd_data, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule